// File: doc/BRIEF.md
# SPI Port with Word Request Handshake

This block is a serial host port that runs either as an SPI slave or as an SPI master, selected by a mode input. Words are shifted MSB first in SPI mode 0: SCK idles low, data is captured on the rising edge and changed after the falling edge. The word length is a parameter and defaults to 24 bits. One outgoing word is held in a single staging register. A load strobe writes it, and it moves into the shift register when a word begins. A completed incoming word appears on `rx_word` together with a one-cycle `rx_valid` pulse.

Flow control uses an active-low request line that works per word, and its direction follows the mode. As a slave, the port drives the line low when it holds a word and is ready for the next transfer. It releases the line on the first SCK rising edge of that word. As a master, the port samples the line and starts exactly one word on each new assertion by the external slave. A two-bit enable field turns the handshake on (any nonzero value) or off (zero). When it is off, the slave stops driving the line and the master ignores it. As a slave, the port ignores SCK while slave select is high and keeps MISO undriven. As a master, it raises a sticky bus-error flag if slave select is seen low.

Internally a state machine with three states controls the port. ST_IDLE → ST_READY when a loaded word is waiting (slave). ST_READY → ST_SHIFT on the first qualified SCK rise (slave). ST_IDLE → ST_SHIFT when a request is armed (master). ST_SHIFT → ST_IDLE on the last bit (slave: last rise; master: the falling edge after the last rise) or when slave select is released mid-word (slave). Any state → ST_IDLE when the mode input changes. In slave mode, SCK, slave select, MOSI and the request input each pass through a two-flop synchronizer before edge detection. In master mode, SCK is divided from the system clock.

Top module: `spi_req_port`

## Requirements
- R1: While reset is asserted, `req_oe`, `miso_oe`, `sck_o`, `rx_valid` and `berr` are all 0.
- R2: In slave mode with `ss_n_i` high, SCK edges have no effect: the request stays asserted, no word is received and `miso_oe` is 0. With `ss_n_i` low, `miso_oe` is 1.
- R3: In slave mode with the handshake enabled, `req_oe` is 1. After `tx_load`, `req_n_o` goes to 0 within 3 clocks. It returns to 1 after the first SCK rising edge of the word.
- R4: In slave mode, `miso_o` shows bit W-1 of the loaded word before the first rise and the next lower bit after each fall. MOSI is sampled on each rise, MSB first. After the W-th rise, `rx_word` holds the received word and `rx_valid` is high for exactly one clock.
- R5: In slave mode, raising `ss_n_i` mid-word drops the word. No `rx_valid` is given, and `req_n_o` stays 1 until the next `tx_load`.
- R6: In master mode with the handshake enabled, each high-to-low transition of `req_n_i` starts exactly one word. Holding the line low starts no further word.
- R7: In master mode `sck_oe` is 1. Each SCK high phase lasts `sck_half` system clocks (a value of 0 acts as 1). SCK is low whenever no word is in progress.
- R8: In master mode, `mosi_o` sends the loaded word MSB first, and each word has exactly W SCK rising edges. `miso_i` is sampled on each rise, and the received word appears on `rx_word` with a one-clock `rx_valid`.
- R9: In master mode, `ss_n_i` low sets `berr`. `berr` stays 1 until `berr_clr` is pulsed with `ss_n_i` high. `ss_n_i` low in slave mode never sets it.
- R10: With `req_en` = 2'b00, `req_oe` is 0 and the master ignores `req_n_i`. Any nonzero `req_en` enables the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1 = master, 0 = slave |
| req_en | input | 2 | Handshake enable field; 00 disables |
| sck_half | input | HALF_W | Master SCK half period in system clocks (divisor = 2 × value) |
| tx_load | input | 1 | Strobe: latch `tx_word` as the next outgoing word |
| tx_word | input | W | Next outgoing word |
| rx_word | output | W | Last received word |
| rx_valid | output | 1 | One-clock pulse when `rx_word` updates |
| berr | output | 1 | Sticky bus-error flag |
| berr_clr | input | 1 | Write-one-to-clear for `berr` |
| sck_i | input | 1 | SCK from external master (slave mode) |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in (slave mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | Drive enable for `miso_o` |
| sck_o | output | 1 | Generated SCK (master mode) |
| sck_oe | output | 1 | Drive enable for `sck_o` and `mosi_o` |
| mosi_o | output | 1 | Serial data out (master mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| req_n_i | input | 1 | Request line input (master mode) |
| req_n_o | output | 1 | Request line output value (slave mode) |
| req_oe | output | 1 | Drive enable for `req_n_o` |

## Verification
A wrong state shows up at the ports within one word, and mostly within a few clocks.

- A slave stuck in ST_READY never releases `req_n_o` after the first SCK rise.
- A slave that leaves ST_READY too early drops the request before any clock arrives.
- A bit counter that is off by one shifts every following bit of both the MISO stream and `rx_word`, and moves `rx_valid` by a whole SCK period.
- A master arm flag that is not cleared when the word starts produces extra SCK rising edges while the request line is held low. This is seen within one `sck_half` period after the word ends.
- A divider reload error changes every measured high phase.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SHIFT = 2'd2
    } port_st_t;

endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
    parameter int              N       = 1,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] meta;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[i] <= RST_VAL[i];
                q[i]    <= RST_VAL[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end

endmodule

// File: rtl/spi_req_edge.sv
module spi_req_edge #(
    parameter int           N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_det
        assign rise[i] = lvl[i] & ~prev[i];
        assign fall[i] = ~lvl[i] & prev[i];
    end

endmodule

// File: rtl/spi_req_sclkgen.sv
module spi_req_sclkgen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              sck,
    output logic              rise,
    output logic              fall
);

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] reload;
    logic              toggle;

    always_comb begin
        reload = (half == '0) ? '0 : half - 1'b1;
        toggle = run && (cnt == '0);
        rise   = toggle && !sck;
        fall   = toggle && sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (!run) begin
            cnt <= reload;
            sck <= 1'b0;
        end else if (toggle) begin
            cnt <= reload;
            sck <= ~sck;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/spi_req_port.sv
module spi_req_port
    import spi_req_pkg::*;
#(
    parameter int W      = 24,
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic [1:0]        req_en,
    input  logic [HALF_W-1:0] sck_half,
    input  logic              tx_load,
    input  logic [W-1:0]      tx_word,
    output logic [W-1:0]      rx_word,
    output logic              rx_valid,
    output logic              berr,
    input  logic              berr_clr,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              req_n_i,
    output logic              req_n_o,
    output logic              req_oe
);

    localparam int               CNT_W    = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(W);

    // synchronized pins: {req_n, mosi, ss_n, sck}
    logic [3:0] sync_q;
    logic [1:0] edg_r, edg_f;
    logic       ss_act, mosi_s, sck_rise, sck_fall, req_fall, req_rise;
    logic       hs_en;

    spi_req_sync #(.N(4), .RST_VAL(4'b1010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({req_n_i, mosi_i, ss_n_i, sck_i}),
        .q     (sync_q)
    );

    spi_req_edge #(.N(2), .RST_VAL(2'b10)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({sync_q[3], sync_q[0]}),
        .rise  (edg_r),
        .fall  (edg_f)
    );

    assign ss_act   = ~sync_q[1];
    assign mosi_s   = sync_q[2];
    assign sck_rise = edg_r[0] & ss_act;
    assign sck_fall = edg_f[0] & ss_act;
    assign req_rise = edg_r[1];
    assign req_fall = edg_f[1];
    assign hs_en    = |req_en;

    port_st_t         st, st_nx;
    logic             mode_q, mode_chg;
    logic [W-1:0]     hold, sh;
    logic             hold_full;
    logic [W-2:0]     rsh;
    logic [CNT_W-1:0] bit_cnt;
    logic             arm;
    logic             start_w, cap_en, cap_bit, shf_en;
    logic             m_run, sck_q, m_rise, m_fall;

    assign m_run = mode_master && (st == ST_SHIFT);

    spi_req_sclkgen #(.HALF_W(HALF_W)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_run),
        .half  (sck_half),
        .sck   (sck_q),
        .rise  (m_rise),
        .fall  (m_fall)
    );

    assign mode_chg = mode_master != mode_q;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (mode_chg)                        st_nx = ST_IDLE;
                else if (!mode_master && hold_full)  st_nx = ST_READY;
                else if (mode_master && arm)         st_nx = ST_SHIFT;
            end
            ST_READY: begin
                if (mode_chg || mode_master)         st_nx = ST_IDLE;
                else if (sck_rise)                   st_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (mode_chg)                        st_nx = ST_IDLE;
                else if (mode_master) begin
                    if (m_fall && bit_cnt == ALL_BITS) st_nx = ST_IDLE;
                end else begin
                    if (!ss_act)                     st_nx = ST_IDLE;
                    else if (sck_rise && bit_cnt == LAST_BIT) st_nx = ST_IDLE;
                end
            end
            default:                                 st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // shift strobes
    always_comb begin
        start_w = (st == ST_IDLE) && (st_nx != ST_IDLE);
        if (mode_master) begin
            cap_en  = (st == ST_SHIFT) && m_rise;
            cap_bit = miso_i;
            shf_en  = (st == ST_SHIFT) && m_fall && (bit_cnt != ALL_BITS);
        end else begin
            cap_en  = ((st == ST_READY) || (st == ST_SHIFT)) && sck_rise;
            cap_bit = mosi_s;
            shf_en  = (st == ST_SHIFT) && sck_fall;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            hold      <= '0;
            hold_full <= 1'b0;
            sh        <= '0;
            rsh       <= '0;
            bit_cnt   <= '0;
            rx_word   <= '0;
            rx_valid  <= 1'b0;
            arm       <= 1'b0;
            berr      <= 1'b0;
        end else begin
            mode_q   <= mode_master;
            rx_valid <= 1'b0;

            if (start_w) begin
                sh        <= hold;
                hold_full <= 1'b0;
            end else if (shf_en) begin
                sh <= {sh[W-2:0], 1'b0};
            end
            if (tx_load) begin
                hold      <= tx_word;
                hold_full <= 1'b1;
            end

            if (cap_en) begin
                rsh     <= {rsh[W-3:0], cap_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    rx_word  <= {rsh, cap_bit};
                    rx_valid <= 1'b1;
                end
            end
            if (st_nx == ST_IDLE) bit_cnt <= '0;

            if (!mode_master || !hs_en)   arm <= 1'b0;
            else if (req_fall)            arm <= 1'b1;
            else if (start_w || req_rise) arm <= 1'b0;

            if (mode_master && ss_act) berr <= 1'b1;
            else if (berr_clr)         berr <= 1'b0;
        end
    end

    // pin outputs
    always_comb begin
        req_oe  = rst_n && !mode_master && hs_en;
        req_n_o = !(!mode_master && (st == ST_READY));
        miso_oe = rst_n && !mode_master && ss_act;
        miso_o  = sh[W-1];
        mosi_o  = sh[W-1];
        sck_o   = sck_q;
        sck_oe  = rst_n && mode_master;
    end

endmodule

// File: rtl/spi_req_port_chk.sv
module spi_req_port_chk
    import spi_req_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mode_master,
    input logic [1:0] req_en,
    input logic       ss_n_i,
    input logic       berr,
    input logic       berr_clr,
    input logic       rx_valid,
    input logic       miso_oe,
    input logic       req_oe,
    input logic       sck_o,
    input port_st_t   st
);

    p_rxv_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_miso_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && $past(ss_n_i, 2)) |-> !miso_oe);

    p_req_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en == 2'b00) |-> !req_oe);

    p_req_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master |-> !req_oe);

    p_berr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (berr && !berr_clr) |=> berr);

    p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> !sck_o);

endmodule

bind spi_req_port spi_req_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .req_en      (req_en),
    .ss_n_i      (ss_n_i),
    .berr        (berr),
    .berr_clr    (berr_clr),
    .rx_valid    (rx_valid),
    .miso_oe     (miso_oe),
    .req_oe      (req_oe),
    .sck_o       (sck_o),
    .st          (st)
);

// File: tb/spi_req_port_bench.sv
module spi_req_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int HALF_W     = 4;
    localparam int SL_HALF    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_master = 1'b0;
    logic [1:0]        req_en = 2'b11;
    logic [HALF_W-1:0] sck_half = 4'd1;
    logic              tx_load = 1'b0;
    logic [W-1:0]      tx_word = '0;
    logic [W-1:0]      rx_word;
    logic              rx_valid, berr;
    logic              berr_clr = 1'b0;
    logic              sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
    logic              miso_o, miso_oe, sck_o, sck_oe, mosi_o, miso_i;
    logic              req_n_i = 1'b1;
    logic              req_n_o, req_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int rv_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_req_port #(.W(W), .HALF_W(HALF_W)) u_spi_req_port (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .req_en(req_en),
        .sck_half(sck_half), .tx_load(tx_load), .tx_word(tx_word),
        .rx_word(rx_word), .rx_valid(rx_valid), .berr(berr), .berr_clr(berr_clr),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o),
        .miso_oe(miso_oe), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
        .miso_i(miso_i), .req_n_i(req_n_i), .req_n_o(req_n_o), .req_oe(req_oe)
    );

    always @(negedge clk) if (rx_valid) rv_cnt++;

    // external slave model used in master mode
    logic [W-1:0] m_pat = '0;
    logic [W-1:0] m_cap = '0;
    int  m_idx = 0, m_hi = 0, m_rises = 0, m_hibad = 0;
    logic m_prev = 1'b0;

    assign miso_i = m_pat[W-1-m_idx];

    always @(negedge clk) begin
        if (mode_master && !req_n_i) begin
            if (sck_o && !m_prev) begin
                m_cap = {m_cap[W-2:0], mosi_o};
                m_hi  = 1;
                m_rises++;
            end else if (sck_o) begin
                m_hi++;
            end else if (m_prev) begin
                if (m_hi != int'(sck_half)) m_hibad++;
                if (m_idx < W - 1) m_idx++;
            end
        end else begin
            m_idx = 0;
            m_hi  = 0;
            if (req_n_i) m_cap = '0;
        end
        m_prev = sck_o;
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [W-1:0] v);
        tx_word = v;
        tx_load = 1'b1;
        ticks(1);
        tx_load = 1'b0;
    endtask

    // one slave-mode word, bench acts as master
    task automatic sl_word(input logic [W-1:0] txv, input logic [W-1:0] rxv, input bit do_load);
        logic [W-1:0] got;
        int rv0;
        if (do_load) begin
            load_word(txv);
            ticks(3);
        end
        chk(req_oe && !req_n_o, "R3", {req_oe, req_n_o}, 2'b10);
        ss_n_i = 1'b0;
        ticks(4);
        chk(miso_oe, "R2", miso_oe, 1);
        got = '0;
        rv0 = rv_cnt;
        for (int i = 0; i < W; i++) begin
            mosi_i = rxv[W-1-i];
            ticks(SL_HALF);
            got = {got[W-2:0], miso_o};
            sck_i = 1'b1;
            ticks(SL_HALF);
            if (i == 0) chk(req_n_o, "R3", req_n_o, 1);
            sck_i = 1'b0;
        end
        ticks(6);
        chk(got == txv, "R4", got, txv);
        chk(rx_word == rxv, "R4", rx_word, rxv);
        chk(rv_cnt == rv0 + 1, "R4", rv_cnt - rv0, 1);
        chk(!berr, "R9", berr, 0);
        ss_n_i = 1'b1;
        ticks(4);
        chk(!miso_oe, "R2", miso_oe, 0);
    endtask

    // one master-mode word, bench acts as slave
    task automatic mw_word(input int half, input logic [W-1:0] txv, input logic [W-1:0] mv,
                           input bit hold_chk);
        int rv0, hb0, r0, r1;
        sck_half = HALF_W'(half);
        m_pat    = mv;
        load_word(txv);
        req_n_i = 1'b1;
        ticks(4);
        rv0 = rv_cnt;
        hb0 = m_hibad;
        r0  = m_rises;
        req_n_i = 1'b0;
        for (int t = 0; t < 4000 && rv_cnt == rv0; t++) ticks(1);
        ticks(2 * half + 4);
        chk(rv_cnt == rv0 + 1, "R6", rv_cnt - rv0, 1);
        chk(rx_word == mv, "R8", rx_word, mv);
        chk(m_cap == txv, "R8", m_cap, txv);
        chk(m_rises - r0 == W, "R8", m_rises - r0, W);
        chk(m_hibad == hb0, "R7", m_hibad - hb0, 0);
        chk(!sck_o && sck_oe, "R7", {sck_o, sck_oe}, 2'b01);
        if (hold_chk) begin
            r1 = m_rises;
            ticks(60);
            chk(m_rises == r1, "R6", m_rises - r1, 0);
            chk(rv_cnt == rv0 + 1, "R6", rv_cnt - rv0, 1);
        end
        req_n_i = 1'b1;
        ticks(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int rv0, r0;
        // R1: reset state
        ticks(3);
        chk(!req_oe && !miso_oe && !sck_o && !rx_valid && !berr, "R1",
            {req_oe, miso_oe, sck_o, rx_valid, berr}, 0);
        rst_n = 1'b1;
        ticks(4);

        // R2: SCK ignored while slave select is high
        load_word(8'h96);
        ticks(3);
        rv0 = rv_cnt;
        for (int i = 0; i < 3; i++) begin
            sck_i = 1'b1; ticks(SL_HALF);
            sck_i = 1'b0; ticks(SL_HALF);
        end
        chk(!req_n_o, "R2", req_n_o, 0);
        chk(!miso_oe, "R2", miso_oe, 0);
        chk(rv_cnt == rv0, "R2", rv_cnt - rv0, 0);
        sl_word(8'h96, 8'h3C, 1'b0);

        // R3/R4: exhaustive slave sweep over all 8-bit receive patterns
        for (int v = 0; v < 256; v++) begin
            req_en = 2'((v % 3) + 1);
            sl_word(W'(v) ^ 8'hA5 ^ W'(v << 3), W'(v), 1'b1);
        end

        // R5: abort mid-word
        load_word(8'hF0);
        ticks(3);
        ss_n_i = 1'b0;
        ticks(4);
        rv0 = rv_cnt;
        for (int i = 0; i < 3; i++) begin
            sck_i = 1'b1; ticks(SL_HALF);
            sck_i = 1'b0; ticks(SL_HALF);
        end
        ss_n_i = 1'b1;
        ticks(6);
        chk(req_n_o, "R5", req_n_o, 1);
        chk(rv_cnt == rv0, "R5", rv_cnt - rv0, 0);
        chk(!miso_oe, "R5", miso_oe, 0);
        sl_word(8'h5A, 8'hC3, 1'b1);

        // R10: handshake disabled in slave mode
        req_en = 2'b00;
        ticks(2);
        chk(!req_oe, "R10", req_oe, 0);
        req_en = 2'b11;
        ticks(2);
        chk(req_oe, "R10", req_oe, 1);

        // R9: bus error in master mode
        ss_n_i = 1'b0;
        ticks(6);
        chk(!berr, "R9", berr, 0);
        ss_n_i = 1'b1;
        ticks(4);
        mode_master = 1'b1;
        ticks(4);
        chk(!req_oe, "R6", req_oe, 0);
        ss_n_i = 1'b0;
        ticks(5);
        chk(berr, "R9", berr, 1);
        ss_n_i = 1'b1;
        ticks(5);
        chk(berr, "R9", berr, 1);
        berr_clr = 1'b1;
        ticks(1);
        berr_clr = 1'b0;
        ticks(1);
        chk(!berr, "R9", berr, 0);

        // R10: master ignores request when disabled
        req_en = 2'b00;
        req_n_i = 1'b1;
        ticks(4);
        r0 = m_rises;
        req_n_i = 1'b0;
        ticks(40);
        chk(m_rises == r0, "R10", m_rises - r0, 0);
        req_n_i = 1'b1;
        req_en = 2'b11;
        ticks(4);

        // R6/R7/R8: master sweep over divisors and patterns
        for (int h = 1; h < 8; h++) begin
            for (int k = 0; k < 12; k++) begin
                req_en = 2'((k % 3) + 1);
                mw_word(h, W'(k * 37 + h), ~W'(k * 53 + h * 7), k == 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule